// File: doc/BRIEF.md
# Watchdog Timer With Guarded Start and Stop

This block is a watchdog timer for a chip's system controller. A 32-bit counter counts up from a programmed load value, paced by a slow tick strobe (nominally 32 kHz) and an optional power-of-two prescaler. If software does not kick the watchdog before the counter passes its all-ones value, the block emits a one-cycle reset pulse and reloads the counter. Software kicks the timer by writing a trigger register. Only a value that differs from the previous trigger value counts as a kick, so software alternates between two patterns.

Starting or stopping the timer takes two consecutive writes of fixed words to a run-control register. A lone stray write therefore cannot turn the timer off. Every bus write is posted: it sits in a holding stage with a per-register pending flag and takes effect a fixed number of slow ticks later. While the timer runs, the block refuses changes to the prescaler setting and to the load value.

Top module: `wdt_core`

## Requirements
- R1: After reset the timer runs, the load register reads 0xFFFB0000, the counter starts from 0xFFFB0000, the prescaler is off with ratio 0, and no write is pending.
- R2: Read addresses (word index on `busAddr`): 0 revision (bits [7:0] = REV_CODE, rest 0), 1 control (bit 5 prescaler enable, bits [4:2] ratio), 2 counter, 3 load, 4 last accepted trigger value, 5 run-control (reads 0), 6 pending status.
- R3: A write sets its pending bit in the next cycle: control bit 0, load bit 2, trigger bit 3, run-control bit 4. The bit clears on the PEND_TICKS-th slow tick after the write, and the write takes effect on that same edge. A write to a register whose bit is still set is dropped.
- R4: Committing 0xBBBB and then 0x4444 to run-control starts the timer.
- R5: Committing 0xAAAA and then 0x5555 to run-control stops the timer.
- R6: If a first word (0xBBBB or 0xAAAA) is followed by any word other than its partner, the sequence is abandoned and the run state does not change.
- R7: Committed writes to control or load have no effect while the timer runs, and take effect while it is stopped.
- R8: A committed trigger value that differs from the last accepted one copies the load value into the counter. A repeat of the last value does nothing.
- R9: While running with the prescaler off, the counter advances by one on every slow tick. With the prescaler on, it advances once every 2^ratio ticks.
- R10: When a step takes the counter past 0xFFFFFFFF, `wdReset` is high for exactly one cycle and the counter reloads from the load value.
- R11: While stopped, the counter changes only through a trigger reload.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| slowTick | input | 1 | One-cycle strobe per slow-domain tick |
| busWrEn | input | 1 | Write strobe |
| busAddr | input | 3 | Register word index |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| wdReset | output | 1 | One-cycle timeout reset pulse |

## Verification
A wrong run flag shows within one slow tick, as a counter that moves when it should hold or holds when it should move. A bad sequence-tracker state shows when the next run-control commit lands. A wrong pending countdown shows in the status register on the very tick when the bit should clear. A lost prescaler phase or a bad wrap shows as a step count over a fixed number of ticks that is off by one or more, or as a reset pulse that is missing or lasts too long. Bench checks measure the counter over windows counted in ticks, so each of these faults shows as an exact numeric mismatch.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PTV_W  = 3;
  localparam int unsigned PEND_W = 5;

  localparam logic [ADDR_W-1:0] ADR_REV   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_LOAD  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_TRIG  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_RUN   = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_PEND  = 3'd6;

  localparam int unsigned PB_CTRL = 0;
  localparam int unsigned PB_LOAD = 2;
  localparam int unsigned PB_TRIG = 3;
  localparam int unsigned PB_RUN  = 4;

  localparam logic [15:0] KEY_START1 = 16'hBBBB;
  localparam logic [15:0] KEY_START2 = 16'h4444;
  localparam logic [15:0] KEY_STOP1  = 16'hAAAA;
  localparam logic [15:0] KEY_STOP2  = 16'h5555;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_START1, SEQ_STOP1} seqStateE;

  typedef struct packed {
    logic              ctrlWe;
    logic [PTV_W:0]    ctrlVal;
    logic              loadWe;
    logic [DATA_W-1:0] loadVal;
    logic              reload;
    logic              run;
  } wdtStrobeT;
endpackage

// File: rtl/wdt_post_chan.sv
module wdt_post_chan #(
  parameter int unsigned W          = 32,
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         slowTick,
  input  logic         wrHit,
  input  logic [W-1:0] wrData,
  output logic         pending,
  output logic         commit,
  output logic [W-1:0] heldData
);
  localparam int unsigned CW = $clog2(PEND_TICKS + 1);

  logic         pendQ;
  logic [CW-1:0] cntQ;
  logic [W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= 1'b0;
      cntQ  <= '0;
      dataQ <= '0;
    end else if (wrHit && !pendQ) begin
      pendQ <= 1'b1;
      cntQ  <= CW'(PEND_TICKS);
      dataQ <= wrData;
    end else if (pendQ && slowTick) begin
      cntQ <= cntQ - 1'b1;
      if (cntQ == CW'(1)) pendQ <= 1'b0;
    end
  end

  assign pending  = pendQ;
  assign commit   = pendQ && slowTick && (cntQ == CW'(1));
  assign heldData = dataQ;
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned PEND_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output wdtStrobeT         stb,
  output logic [PEND_W-1:0] pendStat,
  output logic [DATA_W-1:0] trigVal
);
  logic ctrlPend, loadPend, trigPend, runPend;
  logic ctrlCommit, loadCommit, trigCommit, runCommit;
  logic [PTV_W:0]    ctrlData;
  logic [DATA_W-1:0] loadData, trigData;
  logic [15:0]       runData;

  wdt_post_chan #(.W(PTV_W + 1), .PEND_TICKS(PEND_TICKS)) u_ctrlChan (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .wrHit(busWrEn && busAddr == ADR_CTRL), .wrData(busWrData[PTV_W+2:2]),
    .pending(ctrlPend), .commit(ctrlCommit), .heldData(ctrlData));

  wdt_post_chan #(.W(DATA_W), .PEND_TICKS(PEND_TICKS)) u_loadChan (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .wrHit(busWrEn && busAddr == ADR_LOAD), .wrData(busWrData),
    .pending(loadPend), .commit(loadCommit), .heldData(loadData));

  wdt_post_chan #(.W(DATA_W), .PEND_TICKS(PEND_TICKS)) u_trigChan (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .wrHit(busWrEn && busAddr == ADR_TRIG), .wrData(busWrData),
    .pending(trigPend), .commit(trigCommit), .heldData(trigData));

  wdt_post_chan #(.W(16), .PEND_TICKS(PEND_TICKS)) u_runChan (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .wrHit(busWrEn && busAddr == ADR_RUN), .wrData(busWrData[15:0]),
    .pending(runPend), .commit(runCommit), .heldData(runData));

  // run state and two-word key tracker
  seqStateE seqQ, seqFresh;
  logic runQ;
  logic [DATA_W-1:0] lastTrigQ;

  always_comb begin
    if (runData == KEY_START1)     seqFresh = SEQ_START1;
    else if (runData == KEY_STOP1) seqFresh = SEQ_STOP1;
    else                           seqFresh = SEQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqQ <= SEQ_IDLE;
      runQ <= 1'b1;
    end else if (runCommit) begin
      if (seqQ == SEQ_START1 && runData == KEY_START2) begin
        runQ <= 1'b1;
        seqQ <= SEQ_IDLE;
      end else if (seqQ == SEQ_STOP1 && runData == KEY_STOP2) begin
        runQ <= 1'b0;
        seqQ <= SEQ_IDLE;
      end else begin
        seqQ <= seqFresh;
      end
    end
  end

  logic trigNew;
  assign trigNew = trigCommit && (trigData != lastTrigQ);

  always_ff @(posedge clk) begin
    if (!rstN)        lastTrigQ <= '0;
    else if (trigNew) lastTrigQ <= trigData;
  end

  always_comb begin
    stb.ctrlWe  = ctrlCommit && !runQ;
    stb.ctrlVal = ctrlData;
    stb.loadWe  = loadCommit && !runQ;
    stb.loadVal = loadData;
    stb.reload  = trigNew;
    stb.run     = runQ;
  end

  always_comb begin
    pendStat          = '0;
    pendStat[PB_CTRL] = ctrlPend;
    pendStat[PB_LOAD] = loadPend;
    pendStat[PB_TRIG] = trigPend;
    pendStat[PB_RUN]  = runPend;
  end

  assign trigVal = lastTrigQ;
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter logic [DATA_W-1:0] LOAD_INIT = 32'hFFFB_0000,
  parameter logic [7:0]        REV_CODE  = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  wdtStrobeT         stb,
  input  logic [PEND_W-1:0] pendStat,
  input  logic [DATA_W-1:0] trigVal,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdReset,
  output logic [DATA_W-1:0] counterOut,
  output logic [DATA_W-1:0] loadOut
);
  localparam int unsigned PS_W = (1 << PTV_W) - 1;

  logic              psEnQ;
  logic [PTV_W-1:0]  ptvQ;
  logic [PS_W-1:0]   psCntQ, psLimit;
  logic [DATA_W-1:0] loadQ, countQ;
  logic              wdResetQ, step, atTop;

  assign psLimit = ({{(PS_W-1){1'b0}}, 1'b1} << ptvQ) - 1'b1;
  assign step    = slowTick && (!psEnQ || psCntQ >= psLimit);
  assign atTop   = &countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      psEnQ <= 1'b0;
      ptvQ  <= '0;
      loadQ <= LOAD_INIT;
    end else begin
      if (stb.ctrlWe) {psEnQ, ptvQ} <= stb.ctrlVal;
      if (stb.loadWe) loadQ <= stb.loadVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            psCntQ <= '0;
    else if (!psEnQ)      psCntQ <= '0;
    else if (slowTick)    psCntQ <= (psCntQ >= psLimit) ? '0 : psCntQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ   <= LOAD_INIT;
      wdResetQ <= 1'b0;
    end else begin
      wdResetQ <= 1'b0;
      if (stb.reload) begin
        countQ <= loadQ;
      end else if (stb.run && step) begin
        if (atTop) begin
          countQ   <= loadQ;
          wdResetQ <= 1'b1;
        end else begin
          countQ <= countQ + 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (busAddr)
      ADR_REV:   busRdData = {{(DATA_W-8){1'b0}}, REV_CODE};
      ADR_CTRL:  busRdData = {{(DATA_W-PTV_W-3){1'b0}}, psEnQ, ptvQ, 2'b00};
      ADR_COUNT: busRdData = countQ;
      ADR_LOAD:  busRdData = loadQ;
      ADR_TRIG:  busRdData = trigVal;
      ADR_PEND:  busRdData = {{(DATA_W-PEND_W){1'b0}}, pendStat};
      default:   busRdData = '0;
    endcase
  end

  assign wdReset    = wdResetQ;
  assign counterOut = countQ;
  assign loadOut    = loadQ;
endmodule

// File: rtl/wdt_core.sv
module wdt_core
  import wdt_pkg::*;
#(
  parameter int unsigned       PEND_TICKS = 2,
  parameter logic [DATA_W-1:0] LOAD_INIT  = 32'hFFFB_0000,
  parameter logic [7:0]        REV_CODE   = 8'h31
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slowTick,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              wdReset
);
  wdtStrobeT         stb;
  logic [PEND_W-1:0] pendStat;
  logic [DATA_W-1:0] trigVal, counterVal, loadVal;
  logic              runFlag, reloadStb;

  wdt_ctrl #(.PEND_TICKS(PEND_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .stb(stb), .pendStat(pendStat), .trigVal(trigVal));

  wdt_datapath #(.LOAD_INIT(LOAD_INIT), .REV_CODE(REV_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .stb(stb), .pendStat(pendStat), .trigVal(trigVal), .busAddr(busAddr),
    .busRdData(busRdData), .wdReset(wdReset),
    .counterOut(counterVal), .loadOut(loadVal));

  assign runFlag   = stb.run;
  assign reloadStb = stb.reload;
endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk
  import wdt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              slowTick,
  input logic              busWrEn,
  input logic              wdReset,
  input logic [PEND_W-1:0] pendStat,
  input logic              runFlag,
  input logic              reloadStb,
  input logic [DATA_W-1:0] counterVal,
  input logic [DATA_W-1:0] loadVal
);
  // R3
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendStat & ~$past(pendStat)) != '0) |-> $past(busWrEn));
  // R3
  pend_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(pendStat & ~$past(pendStat)));
  // R3
  pend_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((~pendStat & $past(pendStat)) != '0) |-> $past(slowTick));
  // R7
  load_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(loadVal) |-> $past(!runFlag));
  // R9
  count_paced_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(counterVal) |-> $past(slowTick || reloadStb));
  // R11
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(!runFlag && !reloadStb) |-> $stable(counterVal));
  // R10
  wrap_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdReset |-> ($past(slowTick && runFlag) && counterVal == loadVal));
endmodule

bind wdt_core wdt_core_chk u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
  .wdReset(wdReset), .pendStat(pendStat), .runFlag(runFlag),
  .reloadStb(reloadStb), .counterVal(counterVal), .loadVal(loadVal));

// File: tb/wdt_core_tb.sv
module wdt_core_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowTick = 1'b0;
  logic        busWrEn = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        wdReset;
  int nChecks = 0;
  int nFail = 0;

  localparam logic [2:0] A_REV = 0, A_CTRL = 1, A_CNT = 2, A_LOAD = 3,
                         A_TRIG = 4, A_RUN = 5, A_PEND = 6;

  wdt_core u_dut (.clk(clk), .rstN(rstN), .slowTick(slowTick), .busWrEn(busWrEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData), .wdReset(wdReset));

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (3) @(negedge clk);
      slowTick = 1'b1;
      @(negedge clk);
      slowTick = 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic waitTicks(input int k);
    repeat (k) begin
      do @(posedge clk); while (!slowTick);
    end
    @(negedge clk);
  endtask

  task automatic waitCommit(input int bitIdx);
    logic [31:0] p;
    for (int i = 0; i < 60; i++) begin
      rdReg(A_PEND, p);
      if (!p[bitIdx]) return;
      @(negedge clk);
    end
    check("R3 pending never cleared", p, 32'h0);
  endtask

  task automatic writeCommit(input logic [2:0] a, input logic [31:0] d, input int bitIdx);
    busWrite(a, d);
    waitCommit(bitIdx);
  endtask

  task automatic finishUp();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  task automatic t_reset();
    logic [31:0] d, c0;
    rdReg(A_REV, d);  check("R2 revision", d, 32'h31);
    rdReg(A_CTRL, d); check("R1 control reset", d, 32'h0);
    rdReg(A_LOAD, d); check("R1 load reset", d, 32'hFFFB0000);
    rdReg(A_PEND, d); check("R1 no pending", d, 32'h0);
    rdReg(A_RUN, d);  check("R2 run-control reads 0", d, 32'h0);
    rdReg(A_CNT, c0);
    check("R1 counter near load", {31'b0, (c0 - 32'hFFFB0000) < 32'd8}, 32'h1);
    waitTicks(3);
    rdReg(A_CNT, d);  check("R1 R9 running after reset", d - c0, 32'd3);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    busWrite(A_CTRL, 32'h28);
    rdReg(A_PEND, d); check("R3 control pending set", d, 32'h01);
    waitTicks(1);
    rdReg(A_PEND, d); check("R3 still pending after one tick", d, 32'h01);
    waitTicks(1);
    rdReg(A_PEND, d); check("R3 cleared on second tick", d, 32'h0);
    rdReg(A_CTRL, d); check("R7 control ignored while running", d, 32'h0);
    writeCommit(A_LOAD, 32'h100, 2);
    rdReg(A_LOAD, d); check("R7 load ignored while running", d, 32'hFFFB0000);
    busWrite(A_TRIG, 32'h0000EDCB);
    busWrite(A_TRIG, 32'h00001111);
    rdReg(A_PEND, d); check("R3 trigger pending bit", d, 32'h08);
    waitCommit(3);
    rdReg(A_TRIG, d); check("R3 write during pending dropped", d, 32'h0000EDCB);
  endtask

  task automatic t_stop();
    logic [31:0] c0, d;
    writeCommit(A_RUN, 32'hAAAA, 4);
    writeCommit(A_RUN, 32'h5555, 4);
    rdReg(A_CNT, c0);
    waitTicks(5);
    rdReg(A_CNT, d); check("R5 R11 stopped counter holds", d, c0);
  endtask

  task automatic t_badseq();
    logic [31:0] c0, d;
    writeCommit(A_RUN, 32'hBBBB, 4);
    writeCommit(A_RUN, 32'h1234, 4);
    writeCommit(A_RUN, 32'h4444, 4);
    rdReg(A_CNT, c0);
    waitTicks(4);
    rdReg(A_CNT, d); check("R6 broken start ignored", d, c0);
  endtask

  task automatic t_trigger();
    logic [31:0] d;
    writeCommit(A_LOAD, 32'h1000, 2);
    rdReg(A_LOAD, d); check("R7 load accepted when stopped", d, 32'h1000);
    writeCommit(A_TRIG, 32'hFFFF1234, 3);
    rdReg(A_CNT, d);  check("R8 new trigger reloads", d, 32'h1000);
    writeCommit(A_LOAD, 32'h2000, 2);
    writeCommit(A_TRIG, 32'hFFFF1234, 3);
    rdReg(A_CNT, d);  check("R8 repeated trigger ignored", d, 32'h1000);
    writeCommit(A_TRIG, 32'h0000EDCB, 3);
    rdReg(A_CNT, d);  check("R8 toggled trigger reloads", d, 32'h2000);
  endtask

  task automatic t_prescale();
    logic [31:0] c0, d;
    writeCommit(A_CTRL, 32'h28, 0);
    rdReg(A_CTRL, d); check("R2 R7 control accepted when stopped", d, 32'h28);
    writeCommit(A_RUN, 32'hBBBB, 4);
    writeCommit(A_RUN, 32'h4444, 4);
    rdReg(A_CNT, c0);
    waitTicks(16);
    rdReg(A_CNT, d); check("R4 R9 prescaled by 4", d - c0, 32'd4);
    writeCommit(A_RUN, 32'hAAAA, 4);
    writeCommit(A_RUN, 32'h5555, 4);
    writeCommit(A_CTRL, 32'h0, 0);
    writeCommit(A_RUN, 32'hBBBB, 4);
    writeCommit(A_RUN, 32'h4444, 4);
    rdReg(A_CNT, c0);
    waitTicks(10);
    rdReg(A_CNT, d); check("R9 unscaled rate", d - c0, 32'd10);
  endtask

  task automatic t_overflow();
    logic [31:0] d;
    writeCommit(A_RUN, 32'hAAAA, 4);
    writeCommit(A_RUN, 32'h5555, 4);
    writeCommit(A_LOAD, 32'hFFFFFFF0, 2);
    writeCommit(A_TRIG, 32'h5555AAAA, 3);
    rdReg(A_CNT, d); check("R8 reload before overflow", d, 32'hFFFFFFF0);
    writeCommit(A_RUN, 32'hBBBB, 4);
    writeCommit(A_RUN, 32'h4444, 4);
    waitTicks(15);
    rdReg(A_CNT, d); check("R10 at top", d, 32'hFFFFFFFF);
    check("R10 no pulse before wrap", {31'b0, wdReset}, 32'h0);
    waitTicks(1);
    check("R10 pulse on wrap", {31'b0, wdReset}, 32'h1);
    rdReg(A_CNT, d); check("R10 reload on wrap", d, 32'hFFFFFFF0);
    @(negedge clk);
    check("R10 pulse lasts one cycle", {31'b0, wdReset}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual hung expected done");
    finishUp();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_pending();
    t_stop();
    t_badseq();
    t_trigger();
    t_prescale();
    t_overflow();
    finishUp();
  end
endmodule